// File: doc/BRIEF.md
# Data Cache Maintenance Command Unit

This block carries out maintenance commands on a modelled direct-mapped L1 data cache whose state is a valid bit, a dirty bit and an address tag per line. Software programs it through a small register port: a control register plus four command registers that start a whole-cache invalidate, a whole-cache flush, a single-line invalidate or a single-line flush. Dirty lines leave the unit as writeback requests on a request/acknowledge port that carries the line-aligned address.

A whole-cache command walks every line in index order, spending one cycle on each line that needs no writeback and one handshake on each line that does. A single-line command takes an address, checks that the addressed line is valid and holds the same tag, and acts on that line only. The normal cache traffic that fills lines and marks them dirty arrives on a fill port; the data arrays, lookup and the bus beyond the handshake belong elsewhere.

Top module: `dcache_maint_unit`

## Requirements
- R1: After reset every line is invalid and clean, the control register reads zero, `wb_req` is low and `reg_wait` is low.
- R2: While control bit 0 (cache off) is set, a write to any command register is taken without waiting and changes no line and raises no `wb_req`.
- R3: A write of any value to register select 1 (invalidate all) with control bit 6 clear clears valid and dirty on every line with no writeback, one line per cycle from index 0 upward.
- R4: With control bit 6 set, an invalidate command first writes back each valid dirty line it covers and only drops that line once the acknowledge arrives.
- R5: A write to register select 2 (flush all) writes back every valid dirty line in index order; after each acknowledge that line's dirty bit clears and its valid bit stays set; `wb_req` and `wb_addr` hold steady until acknowledged.
- R6: Register select 3 (invalidate line) acts only on the line indexed by the written address, and only when that line is valid with a matching tag.
- R7: Register select 4 (flush line) writes back the addressed line if it is a valid, dirty, tag-matching line, then clears its dirty bit and keeps it valid.
- R8: A single-line command whose address misses (line invalid or tag different) changes no state and raises no `wb_req`.
- R9: Control bit 8 reads high from the cycle after a flush command, or an invalidate with bit 6 set, is accepted until that command has finished; it stays low for an invalidate with bit 6 clear; writes to it are ignored.
- R10: A register write issued while a command is running sees `reg_wait` high and is accepted on the first clock edge after the running command finishes.
- R11: The line size is 16 << LINE_LEN bytes: the line index is taken from the address bits just above the offset, the offset bits are ignored, and `wb_addr` carries the line's tag and index with zero offset bits.
- R12: Register select 0 reads back control bit 0, bit 6 and status bit 8 with all other bits zero; other selects read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, held until `reg_wait` is low |
| reg_sel | input | 3 | Register select: 0 control, 1 invalidate all, 2 flush all, 3 invalidate line, 4 flush line |
| reg_wdata | input | ADDR_W | Write data (control bits or physical address) |
| reg_rdata | output | ADDR_W | Read data for the selected register |
| reg_wait | output | 1 | Write held off because a command is running |
| fill_en | input | 1 | Cache traffic marks a line valid |
| fill_addr | input | ADDR_W | Address of the filled line |
| fill_dirty | input | 1 | Filled line is dirty |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Line-aligned writeback address |
| wb_ack | input | 1 | Writeback acknowledge |
| line_valid | output | NUM_LINES | Valid bit of each line |
| line_dirty | output | NUM_LINES | Dirty bit of each line |

## Verification
Whole-cache commands run over a populated cache with every third line dirty, with acknowledge latencies of zero and several cycles, so that the one-cycle cost of clean lines is told apart from the handshake cost of dirty ones and address hold under a slow acknowledge is exposed. Invalidate runs with the mode bit clear and set separate plain dropping from write-then-drop. Single-line commands use an address with non-zero offset bits, a hit on a dirty line and a miss on a tag mismatch, which separates correct index extraction, tag checking and offset ignoring. A command issued during a running flush and a command issued with the cache off show the wait behaviour and the disable gate against the reference model's line-state vectors.

// File: rtl/dcm_pkg.sv
// Shared types for the data cache maintenance unit.
// Assumes: register selects are 3 bits; control fields sit at fixed bit positions.
package dcm_pkg;

    typedef enum logic [2:0] {
        SEL_CTRL       = 3'd0,
        SEL_INV_ALL    = 3'd1,
        SEL_FLUSH_ALL  = 3'd2,
        SEL_INV_LINE   = 3'd3,
        SEL_FLUSH_LINE = 3'd4
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_WB   = 2'd2
    } walk_state_e;

    localparam int CTRL_OFF_BIT  = 0;
    localparam int CTRL_MODE_BIT = 6;
    localparam int CTRL_STAT_BIT = 8;

endpackage

// File: rtl/dcm_regs.sv
// Register front end: holds the control bits, decodes command writes and
// holds off every write while a command runs.
// Assumes: reg_wr is held by the requester until reg_wait is low.
module dcm_regs
    import dcm_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_sel,
    input  logic              wdata_off,
    input  logic              wdata_mode,
    input  logic              busy,
    input  logic              status,
    output logic              reg_wait,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              ctrl_off,
    output logic              ctrl_mode,
    output logic              cmd_start,
    output logic              cmd_inv,
    output logic              cmd_single
);

    logic     accept;
    logic     is_cmd;
    reg_sel_e sel;

    assign sel      = reg_sel_e'(reg_sel);
    assign reg_wait = reg_wr && busy;
    assign accept   = reg_wr && !busy;

    // Decode the command kind from the register select.
    always_comb begin
        is_cmd     = 1'b1;
        cmd_inv    = 1'b0;
        cmd_single = 1'b0;
        case (sel)
            SEL_INV_ALL:    cmd_inv = 1'b1;
            SEL_FLUSH_ALL:  cmd_inv = 1'b0;
            SEL_INV_LINE: begin
                cmd_inv    = 1'b1;
                cmd_single = 1'b1;
            end
            SEL_FLUSH_LINE: cmd_single = 1'b1;
            default:        is_cmd = 1'b0;
        endcase
    end

    assign cmd_start = accept && is_cmd && !ctrl_off;

    // Control register update on accepted writes to select 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_off  <= 1'b0;
            ctrl_mode <= 1'b0;
        end else if (accept && sel == SEL_CTRL) begin
            ctrl_off  <= wdata_off;
            ctrl_mode <= wdata_mode;
        end
    end

    // Read mux: only the control register has readable content.
    always_comb begin
        reg_rdata = '0;
        if (sel == SEL_CTRL) begin
            reg_rdata[CTRL_OFF_BIT]  = ctrl_off;
            reg_rdata[CTRL_MODE_BIT] = ctrl_mode;
            reg_rdata[CTRL_STAT_BIT] = status;
        end
    end

    AST_OFF_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_off && !busy) |=> !busy) else $error("cmd started while off"); // R2

endmodule

// File: rtl/dcm_line_state.sv
// Per-line valid, dirty and tag storage of the modelled cache.
// Assumes: a maintenance clear on the same line and cycle as a fill wins.
module dcm_line_state #(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic                 fill_dirty,
    input  logic                 clr_en,
    input  logic [IDX_W-1:0]     clr_idx,
    input  logic                 clr_valid,
    input  logic                 clr_dirty,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [TAG_W-1:0]     rd_tag,
    output logic [NUM_LINES-1:0] valid_vec,
    output logic [NUM_LINES-1:0] dirty_vec
);

    logic [TAG_W-1:0] tag_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic v_q;
        logic d_q;
        logic fill_hit;
        logic clr_hit;

        assign fill_hit = fill_en && (fill_idx == IDX_W'(g));
        assign clr_hit  = clr_en && (clr_idx == IDX_W'(g));

        // Line state: fill sets it, maintenance clears override.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q      <= 1'b0;
                d_q      <= 1'b0;
                tag_q[g] <= '0;
            end else begin
                if (fill_hit) begin
                    v_q      <= 1'b1;
                    d_q      <= fill_dirty;
                    tag_q[g] <= fill_tag;
                end
                if (clr_hit && clr_valid) v_q <= 1'b0;
                if (clr_hit && clr_dirty) d_q <= 1'b0;
            end
        end

        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
    end

    assign rd_tag = tag_q[rd_idx];

    AST_DIRTY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && clr_valid && !fill_en) |=> !valid_vec[$past(clr_idx)]) else $error("line not dropped"); // R3

endmodule

// File: rtl/dcm_walker.sv
// Command engine: walks one line (single-line command) or every line
// (whole-cache command), issuing a writeback handshake for each dirty line
// that needs one and emitting line clear strobes.
// Assumes: the line state at cur_idx is presented combinationally.
module dcm_walker
    import dcm_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic             cmd_inv,
    input  logic             cmd_single,
    input  logic [IDX_W-1:0] cmd_idx,
    input  logic [TAG_W-1:0] cmd_tag,
    input  logic             ctrl_mode,
    input  logic             cur_valid,
    input  logic             cur_dirty,
    input  logic [TAG_W-1:0] cur_tag,
    input  logic             wb_ack,
    output logic [IDX_W-1:0] cur_idx,
    output logic             busy,
    output logic             status,
    output logic             wb_req,
    output logic             clr_en,
    output logic             clr_valid,
    output logic             clr_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    walk_state_e      state_q;
    logic [IDX_W-1:0] idx_q;
    logic             inv_q;
    logic             single_q;
    logic             wbneed_q;
    logic [TAG_W-1:0] tag_q;
    logic             hit;
    logic             last;
    logic             step;
    logic             go_wb;

    assign hit     = cur_valid && (!single_q || cur_tag == tag_q);
    assign last    = single_q || (idx_q == LAST_IDX);
    assign cur_idx = idx_q;
    assign busy    = (state_q != ST_IDLE);
    assign status  = busy && wbneed_q;
    assign wb_req  = (state_q == ST_WB);

    // Per-cycle decision for the line under the walker.
    always_comb begin
        step      = 1'b0;
        go_wb     = 1'b0;
        clr_en    = 1'b0;
        clr_valid = 1'b0;
        clr_dirty = 1'b0;
        case (state_q)
            ST_SCAN: begin
                if (hit && cur_dirty && wbneed_q) begin
                    go_wb = 1'b1;
                end else begin
                    step = 1'b1;
                    if (hit && inv_q) begin
                        clr_en    = 1'b1;
                        clr_valid = 1'b1;
                        clr_dirty = 1'b1;
                    end
                end
            end
            ST_WB: begin
                if (wb_ack) begin
                    step      = 1'b1;
                    clr_en    = 1'b1;
                    clr_dirty = 1'b1;
                    clr_valid = inv_q;
                end
            end
            default: ;
        endcase
    end

    // Walker state, line index and latched command attributes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            inv_q    <= 1'b0;
            single_q <= 1'b0;
            wbneed_q <= 1'b0;
            tag_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_start) begin
                        state_q  <= ST_SCAN;
                        idx_q    <= cmd_single ? cmd_idx : '0;
                        inv_q    <= cmd_inv;
                        single_q <= cmd_single;
                        wbneed_q <= !cmd_inv || ctrl_mode;
                        tag_q    <= cmd_tag;
                    end
                end
                default: begin
                    if (go_wb) begin
                        state_q <= ST_WB;
                    end else if (step) begin
                        if (last) begin
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_SCAN;
                            idx_q   <= idx_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_STATUS_COVERS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> status) else $error("writeback without status"); // R9

endmodule

// File: rtl/dcache_maint_unit.sv
// Top of the data cache maintenance unit: register front end, line state
// store and command walker, plus the writeback address assembly.
// Assumes: ADDR_W > OFFS_W + IDX_W and ADDR_W > 8 so the status bit fits.
module dcache_maint_unit #(
    parameter int ADDR_W    = 32,
    parameter int NUM_LINES = 16,
    parameter int LINE_LEN  = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [2:0]           reg_sel,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata,
    output logic                 reg_wait,
    input  logic                 fill_en,
    input  logic [ADDR_W-1:0]    fill_addr,
    input  logic                 fill_dirty,
    output logic                 wb_req,
    output logic [ADDR_W-1:0]    wb_addr,
    input  logic                 wb_ack,
    output logic [NUM_LINES-1:0] line_valid,
    output logic [NUM_LINES-1:0] line_dirty
);

    localparam int OFFS_W = 4 + LINE_LEN;
    localparam int IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int TAG_W  = ADDR_W - OFFS_W - IDX_W;

    logic             ctrl_off;
    logic             ctrl_mode;
    logic             cmd_start;
    logic             cmd_inv;
    logic             cmd_single;
    logic             busy;
    logic             status;
    logic [IDX_W-1:0] cur_idx;
    logic [TAG_W-1:0] cur_tag;
    logic             clr_en;
    logic             clr_valid;
    logic             clr_dirty;
    logic             unused_offsets;

    assign unused_offsets = ^{reg_wdata[OFFS_W-1:0], fill_addr[OFFS_W-1:0]};

    dcm_regs #(.ADDR_W(ADDR_W)) i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_sel    (reg_sel),
        .wdata_off  (reg_wdata[dcm_pkg::CTRL_OFF_BIT]),
        .wdata_mode (reg_wdata[dcm_pkg::CTRL_MODE_BIT]),
        .busy       (busy),
        .status     (status),
        .reg_wait   (reg_wait),
        .reg_rdata  (reg_rdata),
        .ctrl_off   (ctrl_off),
        .ctrl_mode  (ctrl_mode),
        .cmd_start  (cmd_start),
        .cmd_inv    (cmd_inv),
        .cmd_single (cmd_single)
    );

    dcm_line_state #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill_en    (fill_en),
        .fill_idx   (fill_addr[OFFS_W +: IDX_W]),
        .fill_tag   (fill_addr[ADDR_W-1 -: TAG_W]),
        .fill_dirty (fill_dirty),
        .clr_en     (clr_en),
        .clr_idx    (cur_idx),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty),
        .rd_idx     (cur_idx),
        .rd_tag     (cur_tag),
        .valid_vec  (line_valid),
        .dirty_vec  (line_dirty)
    );

    dcm_walker #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_inv    (cmd_inv),
        .cmd_single (cmd_single),
        .cmd_idx    (reg_wdata[OFFS_W +: IDX_W]),
        .cmd_tag    (reg_wdata[ADDR_W-1 -: TAG_W]),
        .ctrl_mode  (ctrl_mode),
        .cur_valid  (line_valid[cur_idx]),
        .cur_dirty  (line_dirty[cur_idx]),
        .cur_tag    (cur_tag),
        .wb_ack     (wb_ack),
        .cur_idx    (cur_idx),
        .busy       (busy),
        .status     (status),
        .wb_req     (wb_req),
        .clr_en     (clr_en),
        .clr_valid  (clr_valid),
        .clr_dirty  (clr_dirty)
    );

    // Line-aligned writeback address: stored tag, walker index, zero offset.
    assign wb_addr = {cur_tag, cur_idx, {OFFS_W{1'b0}}};

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack && !fill_en) |=> (wb_req && $stable(wb_addr))) else $error("wb dropped"); // R5
    AST_WB_DIRTY_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> (line_valid[cur_idx] && line_dirty[cur_idx])) else $error("wb of clean line"); // R4

endmodule

// File: tb/test_dcache_maint_unit.sv
module test_dcache_maint_unit;

    localparam int NL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_wait;
    logic        fill_en = 1'b0;
    logic [31:0] fill_addr = '0;
    logic        fill_dirty = 1'b0;
    logic        wb_req;
    logic [31:0] wb_addr;
    logic        wb_ack = 1'b0;
    logic [NL-1:0] line_valid;
    logic [NL-1:0] line_dirty;

    dcache_maint_unit i_dcache_maint_unit (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
        .fill_en(fill_en), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .line_valid(line_valid), .line_dirty(line_dirty)
    );

    always #4 clk = ~clk;

    int    n_checks = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    int    ack_lat = 0;
    int    lat_cnt = 0;
    int    hs_count = 0;
    logic [31:0] last_wb = '0;
    bit    saw_wait = 1'b0;
    int    cycles = 0;

    // Reference model state
    bit   m_valid [NL];
    bit   m_dirty [NL];
    int   m_tag   [NL];
    bit   m_off = 0, m_mode = 0, m_inv = 0, m_wbneed = 0, m_pending = 0;
    int   q_idx [$];
    int   q_tag [$];
    bit   q_single [$];

    function automatic logic [31:0] mk_addr(int tag, int idx, int off);
        return {tag[23:0], idx[3:0], off[3:0]};
    endfunction

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model, advanced on each clock edge from pre-edge inputs.
    always @(posedge clk) begin
        bit busy_before;
        if (!rst_n) begin
            foreach (m_valid[i]) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = 0; end
            m_off = 0; m_mode = 0; m_pending = 0;
            q_idx.delete(); q_tag.delete(); q_single.delete();
        end else begin
            busy_before = (q_idx.size() != 0);
            if (wb_req && wb_ack) begin hs_count++; last_wb = wb_addr; end
            if (fill_en) begin
                m_valid[fill_addr[7:4]] = 1;
                m_dirty[fill_addr[7:4]] = fill_dirty;
                m_tag[fill_addr[7:4]]   = int'(fill_addr[31:8]);
            end
            if (busy_before) begin
                int  i;
                bit  hit;
                i   = q_idx[0];
                hit = m_valid[i] && (!q_single[0] || m_tag[i] == q_tag[0]);
                if (m_pending) begin
                    if (wb_ack) begin
                        m_dirty[i] = 0;
                        if (m_inv) m_valid[i] = 0;
                        m_pending = 0;
                        void'(q_idx.pop_front()); void'(q_tag.pop_front()); void'(q_single.pop_front());
                    end
                end else if (hit && m_dirty[i] && m_wbneed) begin
                    m_pending = 1;
                end else begin
                    if (hit && m_inv) begin m_valid[i] = 0; m_dirty[i] = 0; end
                    void'(q_idx.pop_front()); void'(q_tag.pop_front()); void'(q_single.pop_front());
                end
            end
            if (reg_wr && !busy_before) begin
                if (reg_sel == 3'd0) begin
                    m_off = reg_wdata[0]; m_mode = reg_wdata[6];
                end else if (reg_sel <= 3'd4 && !m_off) begin
                    m_inv    = (reg_sel == 3'd1 || reg_sel == 3'd3);
                    m_wbneed = !m_inv || m_mode;
                    if (reg_sel == 3'd1 || reg_sel == 3'd2) begin
                        for (int k = 0; k < NL; k++) begin
                            q_idx.push_back(k); q_tag.push_back(0); q_single.push_back(0);
                        end
                    end else begin
                        q_idx.push_back(int'(reg_wdata[7:4]));
                        q_tag.push_back(int'(reg_wdata[31:8]));
                        q_single.push_back(1);
                    end
                end
            end
        end
    end

    // Cycle-by-cycle comparison against the model, mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NL-1:0] ev, ed;
            bit busy_m;
            busy_m = (q_idx.size() != 0);
            for (int i = 0; i < NL; i++) begin ev[i] = m_valid[i]; ed[i] = m_dirty[i]; end
            chk(wb_req === m_pending, cur_req, "wb_req", 32'(wb_req), 32'(m_pending));
            if (m_pending)
                chk(wb_addr === mk_addr(m_tag[q_idx[0]], q_idx[0], 0), "R11", "wb_addr",
                    wb_addr, mk_addr(m_tag[q_idx[0]], q_idx[0], 0));
            chk(line_valid === ev, cur_req, "line_valid", 32'(line_valid), 32'(ev));
            chk(line_dirty === ed, cur_req, "line_dirty", 32'(line_dirty), 32'(ed));
            chk(reg_wait === (reg_wr && busy_m), "R10", "reg_wait", 32'(reg_wait), 32'(reg_wr && busy_m));
            if (reg_sel == 3'd0) begin
                logic [31:0] er;
                er = '0; er[0] = m_off; er[6] = m_mode; er[8] = busy_m && m_wbneed;
                chk(reg_rdata === er, "R9", "ctrl read", reg_rdata, er);
            end
        end
    end

    // Writeback responder with programmable latency.
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            wb_ack = 0; lat_cnt = 0;
        end else if (wb_ack) begin
            wb_ack = 0; lat_cnt = 0;
        end else if (wb_req) begin
            if (lat_cnt >= ack_lat) wb_ack = 1;
            else lat_cnt++;
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=hang expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        bit w;
        reg_wr = 1; reg_sel = sel; reg_wdata = data;
        do begin
            @(negedge clk); w = reg_wait;
            if (w) saw_wait = 1;
            @(posedge clk); #1;
        end while (w);
        reg_wr = 0; reg_sel = 3'd0;
    endtask

    task automatic fill(int tag, int idx, bit dirty);
        fill_en = 1; fill_addr = mk_addr(tag, idx, idx); fill_dirty = dirty;
        @(posedge clk); #1;
        fill_en = 0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(posedge clk); #1; n++; end while (q_idx.size() != 0 && n < 5000);
        @(posedge clk); #1;
    endtask

    task automatic populate();
        for (int i = 0; i < NL; i++) fill(32'h100 + i, i, (i % 3) == 0);
    endtask

    localparam logic [15:0] DIRTY_SET = 16'b1001_0010_0100_1001;

    initial begin
        int h0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        chk(line_valid === '0, "R1", "reset valid", 32'(line_valid), 0);
        chk(line_dirty === '0, "R1", "reset dirty", 32'(line_dirty), 0);
        chk(wb_req === 1'b0, "R1", "reset wb_req", 32'(wb_req), 0);
        chk(reg_rdata === '0, "R1", "reset ctrl", reg_rdata, 0);
        chk(reg_wait === 1'b0, "R1", "reset wait", 32'(reg_wait), 0);
        @(posedge clk); #1;

        cur_req = "R12";
        wr(3'd0, 32'hFFFF_FFFE);
        @(negedge clk);
        chk(reg_rdata === 32'h40, "R12", "ctrl readback", reg_rdata, 32'h40);
        @(posedge clk); #1;
        wr(3'd0, 32'h0);
        reg_sel = 3'd2; @(negedge clk);
        chk(reg_rdata === 32'h0, "R12", "cmd reg read", reg_rdata, 0);
        @(posedge clk); #1; reg_sel = 3'd0;

        cur_req = "R5";
        populate();
        h0 = hs_count; ack_lat = 0;
        wr(3'd2, 32'h0);
        @(negedge clk);
        chk(reg_rdata[8] === 1'b1, "R9", "status during flush", 32'(reg_rdata[8]), 1);
        wait_idle();
        @(negedge clk);
        chk(line_dirty === '0, "R5", "flush clears dirty", 32'(line_dirty), 0);
        chk(line_valid === 16'hFFFF, "R5", "flush keeps valid", 32'(line_valid), 32'hFFFF);
        chk(hs_count - h0 == 6, "R5", "flush handshakes", hs_count - h0, 6);
        chk(reg_rdata[8] === 1'b0, "R9", "status after flush", 32'(reg_rdata[8]), 0);
        @(posedge clk); #1;

        populate();
        h0 = hs_count; ack_lat = 3;
        wr(3'd2, 32'h1234_5678);
        wait_idle();
        @(negedge clk);
        chk(hs_count - h0 == 6, "R5", "slow ack handshakes", hs_count - h0, 6);
        @(posedge clk); #1;

        cur_req = "R3";
        populate();
        h0 = hs_count;
        wr(3'd1, 32'hDEAD_BEEF);
        @(negedge clk);
        chk(reg_rdata[8] === 1'b0, "R9", "status plain inv", 32'(reg_rdata[8]), 0);
        wait_idle();
        @(negedge clk);
        chk(line_valid === '0, "R3", "inv drops all", 32'(line_valid), 0);
        chk(hs_count == h0, "R3", "inv no writeback", hs_count - h0, 0);
        @(posedge clk); #1;

        cur_req = "R4";
        populate();
        wr(3'd0, 32'h40);
        h0 = hs_count; ack_lat = 2;
        wr(3'd1, 32'h0);
        wait_idle();
        @(negedge clk);
        chk(hs_count - h0 == 6, "R4", "wb-inv handshakes", hs_count - h0, 6);
        chk(line_valid === '0, "R4", "wb-inv drops all", 32'(line_valid), 0);
        @(posedge clk); #1;
        wr(3'd0, 32'h0);

        cur_req = "R6";
        populate();
        h0 = hs_count;
        wr(3'd3, mk_addr(32'h106, 6, 4'hB));
        wait_idle();
        @(negedge clk);
        chk(line_valid === 16'hFFBF, "R6", "line inv valid", 32'(line_valid), 32'hFFBF);
        chk(line_dirty === (DIRTY_SET & 16'hFFBF), "R11", "line inv dirty", 32'(line_dirty), 32'(DIRTY_SET & 16'hFFBF));
        chk(hs_count == h0, "R6", "line inv no wb", hs_count - h0, 0);
        @(posedge clk); #1;

        cur_req = "R7";
        h0 = hs_count; ack_lat = 1;
        wr(3'd4, mk_addr(32'h109, 9, 4'h3));
        wait_idle();
        @(negedge clk);
        chk(hs_count - h0 == 1, "R7", "line flush wb", hs_count - h0, 1);
        chk(last_wb === mk_addr(32'h109, 9, 0), "R7", "line flush addr", last_wb, mk_addr(32'h109, 9, 0));
        chk(line_dirty[9] === 1'b0 && line_valid[9] === 1'b1, "R7", "line flush state",
            32'({line_valid[9], line_dirty[9]}), 32'h2);
        @(posedge clk); #1;

        cur_req = "R8";
        h0 = hs_count;
        wr(3'd4, mk_addr(32'h777, 12, 0));
        wait_idle();
        @(negedge clk);
        chk(hs_count == h0 && line_dirty[12] === 1'b1, "R8", "miss no effect",
            32'(line_dirty[12]), 1);
        @(posedge clk); #1;

        cur_req = "R2";
        wr(3'd0, 32'h1);
        h0 = hs_count;
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0);
        repeat (3) begin @(posedge clk); #1; end
        @(negedge clk);
        chk(line_valid === 16'hFFBF && hs_count == h0, "R2", "off ignores cmds",
            32'(line_valid), 32'hFFBF);
        @(posedge clk); #1;
        wr(3'd0, 32'h0);

        cur_req = "R10";
        populate();
        ack_lat = 5; saw_wait = 0;
        wr(3'd2, 32'h0);
        wr(3'd3, mk_addr(32'h103, 3, 0));
        wait_idle();
        @(negedge clk);
        chk(saw_wait == 1'b1, "R10", "wait seen", 32'(saw_wait), 1);
        chk(line_valid[3] === 1'b0 && line_dirty === '0, "R10", "held cmd applied",
            32'(line_valid[3]), 0);
        @(posedge clk); #1;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule